// File: doc/BRIEF.md
# Product Quotient Remainder Unit

This is a multi-cycle arithmetic execution unit for a 64-bit register machine. It produces these results:

- the low or high half of a 64x64 product, with the high half in signed or unsigned form;
- the low 32 bits of a 32x32 product;
- unsigned and signed quotients and remainders at 32-bit and 64-bit width.

The issuing pipeline presents an 8-bit opcode together with a destination operand, a source operand and a 32-bit immediate. It pulses `start_i` while the unit is idle. The unit raises `busy_o` while its one-bit-per-cycle shift-add multiplier or its restoring divider iterates. It then pulses `done_o` for one cycle with the result.

Some operations cannot produce a result: division by zero, signed overflow, or an opcode outside the unit's set. These finish in the cycle after the start. `done_o` pulses, and one flag says what went wrong. The result is zero in that case and carries no meaning.

Top module: `pqr_unit`

## Requirements
- R1: An opcode is legal when bits [2:0] are 110 and bits [7:4] are one of 3, 4, 5, 6, 7, 8, 9, B, C, D, E, F. Bit 3 set selects the source operand as the second operand. Bit 3 clear selects the immediate, sign-extended to 64 bits. Any other opcode pulses `done_o` one cycle after the start, with `illegal_o` high and the other two flags low.
- R2: Nibble 3 returns the upper 64 bits of the unsigned 128-bit product of the two operands.
- R3: Nibble B returns the upper 64 bits of the signed (two's complement) 128-bit product.
- R4: Nibble 9 returns the lower 64 bits of the 64x64 product. Nibble 8 returns the lower 32 bits of the product of the low 32 bits of each operand.
- R5: Unsigned division works on the low 32 bits of each operand for the 32-bit forms and on all 64 bits for the 64-bit forms. Nibble 4 gives the 32-bit quotient, 5 the 64-bit quotient, 6 the 32-bit remainder and 7 the 64-bit remainder.
- R6: Signed division works on the same widths: nibble C gives the 32-bit quotient, D the 64-bit quotient, E the 32-bit remainder and F the 64-bit remainder. Quotients truncate toward zero, and a remainder has the sign of the dividend.
- R7: For nibbles 4, 6, 8, C and E, result bits [63:32] are zero.
- R8: A division or remainder with a zero second operand (at the operation's width) pulses `done_o` one cycle after the start, with `div_zero_o` high and the other flags low.
- R9: A signed division or remainder pulses `done_o` one cycle after the start, with `div_ovf_o` high, when the dividend is the most negative value of the operation's width and the second operand is -1 at that width. Unsigned division never raises this flag.
- R10: A start is taken only while `busy_o` is low. An operation with a result holds `busy_o` high from the cycle after the start until `done_o` pulses. A start while busy is ignored, and `done_o` is a single-cycle pulse.
- R11: After reset, `busy_o`, `done_o`, all flags and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken while idle |
| opcode_i | input | 8 | Operation code |
| dst_i | input | 64 | First operand (multiplicand / dividend) |
| src_i | input | 64 | Second operand, register form |
| imm_i | input | 32 | Second operand, immediate form |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result, valid with `done_o` |
| div_zero_o | output | 1 | Divide-by-zero, valid with `done_o` |
| div_ovf_o | output | 1 | Signed divide overflow, valid with `done_o` |
| illegal_o | output | 1 | Unknown opcode, valid with `done_o` |

## Verification
The bench sweeps every opcode against operand sets built around zero, one, all-ones and the most negative 64-bit and 32-bit values, in both register and immediate form.

These sets expose the typical faults:
- A missing sign correction gives wrong signed high products and wrong remainder signs.
- Sign-extending instead of zero-extending leaves ones in the upper word of 32-bit results.
- Dropping the immediate's sign extension changes the 64-bit forms.
- A wrong width in the overflow test either divides the most negative value by -1 or flags a harmless 32-bit case.

A start issued while busy, which a faulty handshake would accept and so corrupt the result, is checked separately.

// File: rtl/pqr_pkg.sv
// Shared definitions for the product/quotient/remainder unit.
// Assumes the opcode layout: [7:4] operation, [3] operand form, [2:0] class.
package pqr_pkg;

    localparam int          OPC_W     = 8;
    localparam int          FORM_BIT  = 3;
    localparam logic [2:0]  CLASS_PQR = 3'b110;

    // Decoded operation controls.
    typedef struct packed {
        logic legal;    // opcode belongs to this unit
        logic is_div;   // divider path (else multiplier)
        logic is32;     // 32-bit operation, zero-extended result
        logic sgn;      // signed interpretation
        logic want_hi;  // upper product half
        logic want_rem; // remainder instead of quotient
    } pqr_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } pqr_state_e;

endpackage

// File: rtl/pqr_decode.sv
// Opcode decoder: maps an 8-bit opcode to operation controls.
// Assumes nothing about the operand form bit, which the top handles.
module pqr_decode
    import pqr_pkg::*;
(
    input  logic [3:0] op_hi_i,
    input  logic [2:0] op_cls_i,
    output pqr_dec_t   dec_o
);

    // Table lookup on the operation nibble, gated by the class field.
    always_comb begin
        dec_o = '0;
        unique case (op_hi_i)
            4'h3: begin dec_o.legal = 1'b1; dec_o.want_hi = 1'b1; end
            4'h4: begin dec_o.legal = 1'b1; dec_o.is_div = 1'b1; dec_o.is32 = 1'b1; end
            4'h5: begin dec_o.legal = 1'b1; dec_o.is_div = 1'b1; end
            4'h6: begin dec_o.legal = 1'b1; dec_o.is_div = 1'b1; dec_o.is32 = 1'b1; dec_o.want_rem = 1'b1; end
            4'h7: begin dec_o.legal = 1'b1; dec_o.is_div = 1'b1; dec_o.want_rem = 1'b1; end
            4'h8: begin dec_o.legal = 1'b1; dec_o.is32 = 1'b1; end
            4'h9: begin dec_o.legal = 1'b1; end
            4'hB: begin dec_o.legal = 1'b1; dec_o.sgn = 1'b1; dec_o.want_hi = 1'b1; end
            4'hC: begin dec_o.legal = 1'b1; dec_o.is_div = 1'b1; dec_o.is32 = 1'b1; dec_o.sgn = 1'b1; end
            4'hD: begin dec_o.legal = 1'b1; dec_o.is_div = 1'b1; dec_o.sgn = 1'b1; end
            4'hE: begin dec_o.legal = 1'b1; dec_o.is_div = 1'b1; dec_o.is32 = 1'b1; dec_o.sgn = 1'b1; dec_o.want_rem = 1'b1; end
            4'hF: begin dec_o.legal = 1'b1; dec_o.is_div = 1'b1; dec_o.sgn = 1'b1; dec_o.want_rem = 1'b1; end
            default: dec_o = '0;
        endcase
        if (op_cls_i != CLASS_PQR) begin
            dec_o = '0;
        end
    end

endmodule

// File: rtl/pqr_mul.sv
// Iterative unsigned shift-add multiplier, one multiplier bit per cycle.
// Assumes start_i is only pulsed while busy_o is low; takes W cycles.
module pqr_mul #(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] prod_o
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  mcand_q;
    logic [W-1:0]  hi_q;
    logic [W-1:0]  lo_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    sum;

    // Partial sum for the multiplier bit now at the bottom of lo_q.
    always_comb begin
        sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    end

    // Load, iterate and finish the shift-add sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            cnt_q   <= '0;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                mcand_q <= a_i;
                hi_q    <= '0;
                lo_q    <= b_i;
                cnt_q   <= '0;
                busy_o  <= 1'b1;
            end else if (busy_o) begin
                hi_q  <= sum[W:1];
                lo_q  <= {sum[0], lo_q[W-1:1]};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(W-1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign prod_o = {hi_q, lo_q};

    AST_MUL_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_MUL_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o); // R10

endmodule

// File: rtl/pqr_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes a non-zero divisor and start_i only while busy_o is low.
module pqr_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  den_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          take;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, den_q};
        take    = !diff[W];
    end

    // Load, iterate and finish the restoring division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                den_q  <= den_i;
                rem_q  <= '0;
                quo_q  <= num_i;
                cnt_q  <= '0;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                rem_q <= take ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], take};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(W-1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && den_q != '0) |-> (rem_q < den_q)); // R5
    AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10

endmodule

// File: rtl/pqr_unit.sv
// Product/quotient/remainder execution unit with a start/busy/done handshake.
// Decodes the opcode, screens exceptions in the start cycle, runs the
// multiplier or divider on magnitudes and applies sign and width fixes.
// Assumes the issuer holds off start_i while busy_o is high (ignored if not).
module pqr_unit
    import pqr_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [XLEN-1:0] dst_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o,
    output logic            div_zero_o,
    output logic            div_ovf_o,
    output logic            illegal_o
);

    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] MIN_FULL = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [HALF-1:0] MIN_HALF = {1'b1, {(HALF-1){1'b0}}};

    pqr_dec_t        dec;
    pqr_dec_t        dec_q;
    pqr_state_e      state_q;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] a_ext;
    logic [XLEN-1:0] b_ext;
    logic            sa;
    logic            sb;
    logic            sa_q;
    logic            sb_q;
    logic [XLEN-1:0] araw_q;
    logic [XLEN-1:0] braw_q;
    logic            zero_div;
    logic            ovf_div;
    logic            accept;
    logic            mul_start;
    logic            div_start;
    logic            mul_busy;
    logic            mul_done;
    logic            div_busy;
    logic            div_done;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0] quo;
    logic [XLEN-1:0] rem;
    logic [XLEN-1:0] mul_res;
    logic [XLEN-1:0] div_res;
    logic [XLEN-1:0] raw_res;
    logic [XLEN-1:0] final_res;

    pqr_decode u_dec (
        .op_hi_i  (opcode_i[7:4]),
        .op_cls_i (opcode_i[2:0]),
        .dec_o    (dec)
    );

    // Second operand: register, or immediate sign-extended to full width.
    always_comb begin
        opb = opcode_i[FORM_BIT] ? src_i
                                 : {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end

    // Width/sign extension of both operands and exception screening.
    always_comb begin
        if (dec.is32) begin
            a_ext = dec.sgn ? {{HALF{dst_i[HALF-1]}}, dst_i[HALF-1:0]} : {{HALF{1'b0}}, dst_i[HALF-1:0]};
            b_ext = dec.sgn ? {{HALF{opb[HALF-1]}}, opb[HALF-1:0]}     : {{HALF{1'b0}}, opb[HALF-1:0]};
            ovf_div = dec.sgn && (dst_i[HALF-1:0] == MIN_HALF) && (&opb[HALF-1:0]);
        end else begin
            a_ext = dst_i;
            b_ext = opb;
            ovf_div = dec.sgn && (dst_i == MIN_FULL) && (&opb);
        end
        sa       = dec.sgn && a_ext[XLEN-1];
        sb       = dec.sgn && b_ext[XLEN-1];
        zero_div = (b_ext == '0);
        accept   = start_i && (state_q == ST_IDLE);
    end

    assign mul_start = accept && dec.legal && !dec.is_div;
    assign div_start = accept && dec.legal && dec.is_div && !zero_div && !ovf_div;

    pqr_mul #(.W(XLEN)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mul_start),
        .a_i     (a_ext),
        .b_i     (b_ext),
        .busy_o  (mul_busy),
        .done_o  (mul_done),
        .prod_o  (prod)
    );

    pqr_div #(.W(XLEN)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (sa ? (XLEN'(0) - a_ext) : a_ext),
        .den_i   (sb ? (XLEN'(0) - b_ext) : b_ext),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quo_o   (quo),
        .rem_o   (rem)
    );

    // Sign correction of engine outputs and 32-bit zero extension.
    always_comb begin
        if (dec_q.want_hi) begin
            mul_res = prod[2*XLEN-1:XLEN];
            if (dec_q.sgn) begin
                mul_res = mul_res - (araw_q[XLEN-1] ? braw_q : '0)
                                  - (braw_q[XLEN-1] ? araw_q : '0);
            end
        end else begin
            mul_res = prod[XLEN-1:0];
        end
        if (dec_q.want_rem) begin
            div_res = sa_q ? (XLEN'(0) - rem) : rem;
        end else begin
            div_res = (sa_q ^ sb_q) ? (XLEN'(0) - quo) : quo;
        end
        raw_res   = dec_q.is_div ? div_res : mul_res;
        final_res = dec_q.is32 ? {{HALF{1'b0}}, raw_res[HALF-1:0]} : raw_res;
    end

    // Sequencer: take a start, report early exceptions, collect engine results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            dec_q      <= '0;
            sa_q       <= 1'b0;
            sb_q       <= 1'b0;
            araw_q     <= '0;
            braw_q     <= '0;
            done_o     <= 1'b0;
            result_o   <= '0;
            div_zero_o <= 1'b0;
            div_ovf_o  <= 1'b0;
            illegal_o  <= 1'b0;
        end else begin
            done_o     <= 1'b0;
            div_zero_o <= 1'b0;
            div_ovf_o  <= 1'b0;
            illegal_o  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        dec_q  <= dec;
                        sa_q   <= sa;
                        sb_q   <= sb;
                        araw_q <= a_ext;
                        braw_q <= b_ext;
                        if (!dec.legal) begin
                            done_o    <= 1'b1;
                            illegal_o <= 1'b1;
                            result_o  <= '0;
                        end else if (dec.is_div && zero_div) begin
                            done_o     <= 1'b1;
                            div_zero_o <= 1'b1;
                            result_o   <= '0;
                        end else if (dec.is_div && ovf_div) begin
                            done_o    <= 1'b1;
                            div_ovf_o <= 1'b1;
                            result_o  <= '0;
                        end else begin
                            state_q <= dec.is_div ? ST_DIV : ST_MUL;
                        end
                    end
                end
                ST_MUL: begin
                    if (mul_done) begin
                        result_o <= final_res;
                        done_o   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        result_o <= final_res;
                        done_o   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_zero_o || div_ovf_o || illegal_o) |-> done_o); // R8
    AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({div_zero_o, div_ovf_o, illegal_o}) <= 1); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dec_q.is32 && !div_zero_o && !div_ovf_o && !illegal_o)
            |-> (result_o[XLEN-1:HALF] == '0)); // R7
    AST_RESULT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o && !div_ovf_o && !illegal_o) |-> $past(busy_o)); // R10
    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_start || div_start) |=> (busy_o && (mul_busy || div_busy))); // R10

endmodule

// File: tb/pqr_unit_tb_top.sv
module pqr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic [31:0] imm_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] result_o;
    logic        div_zero_o;
    logic        div_ovf_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pqr_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .opcode_i   (opcode_i),
        .dst_i      (dst_i),
        .src_i      (src_i),
        .imm_i      (imm_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o),
        .div_zero_o (div_zero_o),
        .div_ovf_o  (div_ovf_o),
        .illegal_o  (illegal_o)
    );

    function automatic string tag_of(input logic [3:0] nib);
        case (nib)
            4'h3: return "R2";
            4'hB: return "R3";
            4'h8, 4'h9: return "R4";
            4'h4, 4'h5, 4'h6, 4'h7: return "R5";
            4'hC, 4'hD, 4'hE, 4'hF: return "R6";
            default: return "R1";
        endcase
    endfunction

    // Reference model computed from the requirements.
    function automatic void model(input logic [7:0] op, input logic [63:0] a,
                                  input logic [63:0] s, input logic [31:0] im,
                                  output logic [63:0] r, output logic ez,
                                  output logic eo, output logic ei);
        logic [63:0]  b;
        logic [127:0] pu;
        logic signed [127:0] ps;
        logic signed [63:0] sa64, sb64;
        logic signed [31:0] sa32, sb32;
        logic [3:0] n;
        logic is_div, is32, sgn;
        b  = op[3] ? s : {{32{im[31]}}, im};
        n  = op[7:4];
        r  = '0; ez = 0; eo = 0;
        ei = (op[2:0] != 3'b110) || (n < 4'h3) || (n == 4'hA);
        is_div = (n inside {4'h4,4'h5,4'h6,4'h7,4'hC,4'hD,4'hE,4'hF});
        is32   = (n inside {4'h4,4'h6,4'h8,4'hC,4'hE});
        sgn    = (n >= 4'hB);
        if (ei) return;
        if (is_div) begin
            ez = is32 ? (b[31:0] == 0) : (b == 0);
            if (ez) return;
            if (sgn) begin
                eo = is32 ? (a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF)
                          : (a == 64'h8000_0000_0000_0000 && b == '1);
                if (eo) return;
            end
        end
        sa64 = a; sb64 = b; sa32 = a[31:0]; sb32 = b[31:0];
        pu = {64'b0, a} * {64'b0, b};
        ps = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
        case (n)
            4'h3: r = pu[127:64];
            4'h4: r = {32'b0, a[31:0] / b[31:0]};
            4'h5: r = a / b;
            4'h6: r = {32'b0, a[31:0] % b[31:0]};
            4'h7: r = a % b;
            4'h8: r = {32'b0, pu[31:0]};
            4'h9: r = pu[63:0];
            4'hB: r = ps[127:64];
            4'hC: r = {32'b0, 32'(sa32 / sb32)};
            4'hD: r = 64'(sa64 / sb64);
            4'hE: r = {32'b0, 32'(sa32 % sb32)};
            4'hF: r = 64'(sa64 % sb64);
            default: r = '0;
        endcase
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [63:0] a,
                          input logic [63:0] s, input logic [31:0] im);
        logic [63:0] er;
        logic ez, eo, ei;
        int n;
        string tg;
        model(op, a, s, im, er, ez, eo, ei);
        tg = op[3] ? tag_of(op[7:4]) : {"R1 ", tag_of(op[7:4])};
        if (ez) tg = "R8";
        if (eo) tg = "R9";
        if (ei) tg = "R1";
        @(negedge clk);
        opcode_i = op; dst_i = a; src_i = s; imm_i = im; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 300) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (!done_o || div_zero_o !== ez || div_ovf_o !== eo || illegal_o !== ei ||
            (!(ez || eo || ei) && result_o !== er)) begin
            errors++;
            $display("FAIL %s op=%h a=%h b=%h imm=%h: got done=%b res=%h z=%b o=%b i=%b, exp res=%h z=%b o=%b i=%b",
                     tg, op, a, s, im, done_o, result_o, div_zero_o, div_ovf_o, illegal_o,
                     er, ez, eo, ei);
        end
        if (!(ez || eo || ei) && (op[7:4] inside {4'h4,4'h6,4'h8,4'hC,4'hE})) begin
            checks++;
            if (result_o[63:32] !== 32'h0) begin
                errors++;
                $display("FAIL R7 op=%h upper word got %h exp 0", op, result_o[63:32]);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] vals [8];
        logic [31:0] imms [6];
        logic [3:0]  nibs [12];
        logic [63:0] lfsr;
        logic [63:0] exp_v;
        vals = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7,
                 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
                 64'h0000_0000_8000_0000, 64'h1234_5678_9ABC_DEF1};
        imms = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h5, 32'hFFFF_FFF9};
        nibs = '{4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        checks++;
        if (busy_o !== 1'b0 || done_o !== 1'b0 || result_o !== 64'h0 ||
            div_zero_o !== 1'b0 || div_ovf_o !== 1'b0 || illegal_o !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: got busy=%b done=%b res=%h flags=%b%b%b exp all zero",
                     busy_o, done_o, result_o, div_zero_o, div_ovf_o, illegal_o);
        end

        // R1: opcodes outside the set
        run_op(8'h06, 64'd5, 64'd3, 32'd0);
        run_op(8'hA6, 64'd5, 64'd3, 32'd0);
        run_op(8'h2E, 64'd5, 64'd3, 32'd0);
        run_op(8'h3C, 64'd5, 64'd3, 32'd0);

        // Register-form sweep over every operation
        foreach (nibs[k]) foreach (vals[i]) foreach (vals[j])
            run_op({nibs[k], 4'hE}, vals[i], vals[j], 32'h0);

        // Immediate-form sweep (R1 sign extension)
        foreach (nibs[k]) foreach (vals[i]) foreach (imms[j])
            run_op({nibs[k], 4'h6}, vals[i], 64'hDEAD_BEEF_0000_0000, imms[j]);

        // Pseudo-random register-form operands
        lfsr = 64'hACE1_2468_1357_9BDF;
        for (int t = 0; t < 150; t++) begin
            logic [63:0] x;
            logic [63:0] y;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            x = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            y = (t % 3 == 0) ? (lfsr >> (t % 40)) : lfsr;
            run_op({nibs[t % 12], 4'hE}, x, y, 32'h0);
        end

        // R10: start while busy is ignored, done is a single pulse
        @(negedge clk);
        opcode_i = 8'h5E; dst_i = 64'd100; src_i = 64'd7; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        checks++;
        if (busy_o !== 1'b1) begin
            errors++;
            $display("FAIL R10 busy after start: got %b exp 1", busy_o);
        end
        @(negedge clk);
        opcode_i = 8'h9E; dst_i = 64'd3; src_i = 64'd5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 0; n < 300 && !done_o; n++) @(negedge clk);
        exp_v = 64'd14;
        checks++;
        if (done_o !== 1'b1 || result_o !== exp_v) begin
            errors++;
            $display("FAIL R10 start while busy: got done=%b res=%h exp done=1 res=%h",
                     done_o, result_o, exp_v);
        end
        @(negedge clk);
        checks++;
        if (done_o !== 1'b0 || busy_o !== 1'b0) begin
            errors++;
            $display("FAIL R10 pulse width: got done=%b busy=%b exp 0 0", done_o, busy_o);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule